// File: doc/BRIEF.md
# Keyboard Scan Code Wake Detector

This block listens to the two-wire serial keyboard link (clock and data, both driven by the keyboard) and rebuilds every frame it carries. The keyboard clock is not used as a clock: it is brought into the system clock domain through synchronizer flops, and the data line is sampled on each falling edge of the synchronized keyboard clock. Once a whole frame has arrived, its start, parity and stop bits are checked, and its data byte is compared with one scan code that software has programmed.

When a well-formed frame carries exactly the programmed byte, the block raises a wake event for a single system clock cycle. A wake status aggregator elsewhere in the chip consumes this event. The comparison byte sits in a register on a small write/read port at address 0x11. It is cleared only by the standby-power reset, so it keeps its value while the main logic is reset. If the keyboard clock stops in the middle of a frame for longer than a programmable timeout, the partial frame is thrown away.

Top module: `kbd_wake_match`

## Requirements
- R1: After reset the wake output is 0, and after the standby-power reset the scan-code register reads 0x00.
- R2: A write with address 0x11 loads the scan-code register, and a read at 0x11 returns it. Reads at any other address return 0x00. Writes at any other address leave the register unchanged.
- R3: The main reset `rst_n` does not change the scan-code register. Only `por_n` clears it.
- R4: A frame is 11 bits, each sampled on a falling keyboard-clock edge. In order they are: a start bit of 0, eight data bits least significant bit first, an odd parity bit (data plus parity hold an odd number of ones), and a stop bit of 1. A high line level is logic 1.
- R5: A valid frame whose data byte differs from the register produces no wake event. This includes the bit-reversed byte.
- R6: A frame whose start bit is 1 produces no wake event.
- R7: A frame whose parity bit gives an even count of ones produces no wake event.
- R8: A frame whose stop bit is 0 produces no wake event.
- R9: If no falling keyboard-clock edge arrives for TIMEOUT_US microseconds of system clocks while a frame is partly received, the receiver drops the partial frame. The next frame then decodes from its start bit.
- R10: Each matching frame gives a wake pulse that lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Main reset, active low, clears the receiver and the wake output |
| por_n | input | 1 | Standby-power reset, active low, clears the scan-code register |
| kbd_clk_i | input | 1 | Keyboard serial clock, asynchronous |
| kbd_dat_i | input | 1 | Keyboard serial data, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| wake_o | output | 1 | One-cycle wake event on a scan code match |

## Verification
The bench sends the programmed byte and its bit-reversed image. A receiver that shifted the data in most significant bit first would wake on the wrong one of the two. It also sends frames that have exactly one of the start, parity or stop bits wrong. A checker that skipped any one of those fields would wake on a corrupt frame. It stops the keyboard clock in the middle of a frame for longer than the timeout and then sends a clean matching frame. A receiver without the timeout would stay misaligned and miss that wake. Pulse width is also checked, together with register retention across the main reset, so a level-type wake output or a register cleared by the wrong reset would show up.

// File: rtl/kwm_pkg.sv
package kwm_pkg;
  localparam int KWM_DATA_W  = 8;
  localparam int KWM_FRAME_W = KWM_DATA_W + 3;

  typedef logic [KWM_DATA_W-1:0] kwm_byte_t;

  // Field order matches arrival order: start arrives first (bit 0).
  typedef struct packed {
    logic      stop;
    logic      parity;
    kwm_byte_t data;
    logic      start;
  } kwm_frame_t;

  // Odd parity: data and parity bit together carry an odd count of ones.
  function automatic logic kwm_parity_ok(kwm_byte_t d, logic p);
    return ((^d) ^ p) == 1'b1;
  endfunction

  function automatic logic kwm_frame_ok(kwm_frame_t f);
    return (f.start == 1'b0) && (f.stop == 1'b1) && kwm_parity_ok(f.data, f.parity);
  endfunction
endpackage

// File: rtl/kwm_sync.sv
module kwm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/kwm_frame_rx.sv
module kwm_frame_rx
  import kwm_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100000,
  localparam int CNT_W = $clog2(KWM_FRAME_W + 1),
  localparam int TMR_W = $clog2(TIMEOUT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kclk_s_i,
  input  logic             kdat_s_i,
  output logic             fall_evt_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             frm_done_o,
  output logic             frm_good_o,
  output kwm_byte_t        frm_data_o
);
  logic             kclk_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [TMR_W-1:0] tmr;
  kwm_frame_t       sh;
  kwm_frame_t       sh_nxt;
  logic             last_bit;
  logic             tmo_hit;

  assign fall_evt_o = kclk_d & ~kclk_s_i;
  assign sh_nxt     = kwm_frame_t'({kdat_s_i, sh[KWM_FRAME_W-1:1]});
  assign last_bit   = (bit_cnt == CNT_W'(KWM_FRAME_W - 1));
  assign tmo_hit    = (bit_cnt != '0) && (tmr == TMR_W'(TIMEOUT_CYC - 1)) && !fall_evt_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kclk_d     <= 1'b1;
      bit_cnt    <= '0;
      tmr        <= '0;
      sh         <= '0;
      frm_done_o <= 1'b0;
      frm_good_o <= 1'b0;
      frm_data_o <= '0;
    end else begin
      kclk_d     <= kclk_s_i;
      frm_done_o <= 1'b0;
      if (fall_evt_o) begin
        sh  <= sh_nxt;
        tmr <= '0;
        if (last_bit) begin
          bit_cnt    <= '0;
          frm_done_o <= 1'b1;
          frm_good_o <= kwm_frame_ok(sh_nxt);
          frm_data_o <= sh_nxt.data;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (tmo_hit) begin
        bit_cnt <= '0;
        tmr     <= '0;
      end else if (bit_cnt != '0) begin
        tmr <= tmr + 1'b1;
      end else begin
        tmr <= '0;
      end
    end
  end

  assign bit_cnt_o = bit_cnt;
endmodule

// File: rtl/kwm_code_reg.sv
module kwm_code_reg
  import kwm_pkg::*;
#(
  parameter int        ADDR_W     = 8,
  parameter int        CODE_ADDR  = 'h11,
  parameter kwm_byte_t RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  kwm_byte_t         wdata_i,
  output kwm_byte_t         code_o,
  output kwm_byte_t         rdata_o
);
  logic hit;
  assign hit = (addr_i == ADDR_W'(CODE_ADDR));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          code_o <= RESET_CODE;
    else if (wr_i && hit) code_o <= wdata_i;
  end

  assign rdata_o = hit ? code_o : '0;
endmodule

// File: rtl/kbd_wake_match.sv
module kbd_wake_match
  import kwm_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TIMEOUT_US  = 2000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int CODE_ADDR   = 'h11,
  localparam int TO_CYC     = (CLK_HZ / 1_000_000) * TIMEOUT_US,
  localparam int CNT_W      = $clog2(KWM_FRAME_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_n,
  input  logic                  kbd_clk_i,
  input  logic                  kbd_dat_i,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [KWM_DATA_W-1:0] reg_wdata_i,
  output logic [KWM_DATA_W-1:0] reg_rdata_o,
  output logic                  wake_o
);
  logic             kclk_s;
  logic             kdat_s;
  logic             fall_evt;
  logic [CNT_W-1:0] bit_cnt;
  logic             frm_done;
  logic             frm_good;
  kwm_byte_t        frm_data;
  kwm_byte_t        code_q;
  logic             match_evt;

  kwm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d_i(kbd_clk_i), .q_o(kclk_s));

  kwm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d_i(kbd_dat_i), .q_o(kdat_s));

  kwm_frame_rx #(.TIMEOUT_CYC(TO_CYC)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .kclk_s_i   (kclk_s),
    .kdat_s_i   (kdat_s),
    .fall_evt_o (fall_evt),
    .bit_cnt_o  (bit_cnt),
    .frm_done_o (frm_done),
    .frm_good_o (frm_good),
    .frm_data_o (frm_data)
  );

  kwm_code_reg #(.ADDR_W(ADDR_W), .CODE_ADDR(CODE_ADDR), .RESET_CODE('0)) u_code (
    .clk     (clk),
    .por_n   (por_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .code_o  (code_q),
    .rdata_o (reg_rdata_o)
  );

  assign match_evt = frm_done && frm_good && (frm_data == code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_o <= 1'b0;
    else        wake_o <= match_evt;
  end
endmodule

// File: rtl/kwm_chk.sv
module kwm_chk #(
  parameter int TO_CYC    = 100000,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int CODE_ADDR = 'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_o,
  input logic              frm_done,
  input logic              frm_good,
  input logic              fall_evt,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o
);
  localparam int QW = $clog2(TO_CYC + 2) + 1;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     quiet <= '0;
    else if (fall_evt)              quiet <= '0;
    else if (quiet != QW'(TO_CYC + 1)) quiet <= quiet + 1'b1;
  end

  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R4
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(frm_done));

  // R8
  wake_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(frm_good));

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(11));

  // R9
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= QW'(TO_CYC)) |-> (bit_cnt == '0));

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr_i && reg_addr_i == ADDR_W'(CODE_ADDR)) && reg_addr_i == ADDR_W'(CODE_ADDR))
      |-> reg_rdata_o == $past(reg_wdata_i));
endmodule

bind kbd_wake_match kwm_chk #(
  .TO_CYC(TO_CYC), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CODE_ADDR(CODE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_o(wake_o), .frm_done(frm_done),
  .frm_good(frm_good), .fall_evt(fall_evt), .bit_cnt(bit_cnt),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o)
);

// File: tb/kbd_wake_match_test.sv
module kbd_wake_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       kbd_clk = 1'b1;
  logic       kbd_dat = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wake;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string exp_q[$];
  logic  prev_wake = 1'b0;

  always #10 clk = ~clk;

  kbd_wake_match #(.CLK_HZ(50_000_000), .TIMEOUT_US(20)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .kbd_clk_i(kbd_clk), .kbd_dat_i(kbd_dat),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .wake_o(wake)
  );

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected item for each wake pulse.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake && prev_wake) check("R10 pulse width", 1'b0, 2, 1);
      if (wake) begin
        if (exp_q.size() == 0) check("R5-R8 unexpected wake", 1'b0, 1, 0);
        else check({exp_q.pop_front(), " wake seen"}, 1'b1, 1, 1);
      end
    end
    prev_wake <= wake;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check("watchdog", 1'b0, cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata == exp, reg_rdata, exp);
  endtask

  task automatic send_bit(input logic b);
    kbd_dat = b;
    wait_clk(10);
    kbd_clk = 1'b0;
    wait_clk(20);
    kbd_clk = 1'b1;
    wait_clk(10);
  endtask

  // Driver: start, data LSB first, odd parity, stop; pushes expectation.
  task automatic send_frame(input string req, input logic [7:0] d, input logic bad_start,
                            input logic bad_par, input logic bad_stop, input logic expect_wake);
    int ones = 0;
    logic par;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    par = (ones % 2 == 0) ? 1'b1 : 1'b0;
    if (bad_par) par = ~par;
    if (expect_wake) exp_q.push_back(req);
    send_bit(bad_start ? 1'b1 : 1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(par);
    send_bit(bad_stop ? 1'b0 : 1'b1);
    kbd_dat = 1'b1;
    wait_clk(40);
    check({req, " expected wakes drained"}, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    wait_clk(5);
    por_n = 1'b1;
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    check("R1 wake after reset", wake == 1'b0, wake, 0);
    reg_read_check("R1 code after por", 8'h11, 8'h00);

    // R2 register access
    reg_write(8'h11, 8'h1C);
    reg_read_check("R2 readback", 8'h11, 8'h1C);
    reg_read_check("R2 other addr reads zero", 8'h12, 8'h00);
    reg_write(8'h12, 8'hFF);
    reg_read_check("R2 other addr write ignored", 8'h11, 8'h1C);

    // R3 main reset keeps register
    wait_clk(1); rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
    reg_read_check("R3 kept over rst_n", 8'h11, 8'h1C);

    // R4/R10 matching frames
    send_frame("R4 match 1C", 8'h1C, 0, 0, 0, 1);
    send_frame("R10 match again", 8'h1C, 0, 0, 0, 1);

    // R5 non-matching, including bit-reversed 0x38
    send_frame("R5 reversed byte", 8'h38, 0, 0, 0, 0);
    send_frame("R5 other byte", 8'h1D, 0, 0, 0, 0);

    // R6 / R7 / R8 corrupted frames
    send_frame("R6 bad start", 8'h1C, 1, 0, 0, 0);
    wait_clk(1200);
    send_frame("R7 bad parity", 8'h1C, 0, 1, 0, 0);
    send_frame("R8 bad stop", 8'h1C, 0, 0, 1, 0);
    wait_clk(1200);

    // R4 other code values
    reg_write(8'h11, 8'hF0);
    send_frame("R4 match F0", 8'hF0, 0, 0, 0, 1);
    reg_write(8'h11, 8'h00);
    send_frame("R4 match 00", 8'h00, 0, 0, 0, 1);

    // R9 timeout discards partial frame
    reg_write(8'h11, 8'h5A);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    kbd_dat = 1'b1;
    wait_clk(1500);
    send_frame("R9 frame after timeout", 8'h5A, 0, 0, 0, 1);

    // R3 standby reset clears register
    wait_clk(1); por_n = 1'b0; wait_clk(2); por_n = 1'b1; wait_clk(2);
    reg_read_check("R3 cleared by por_n", 8'h11, 8'h00);

    wait_clk(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule